// File: doc/BRIEF.md
# Taken-Branch Target Cache for the Fetch Stage

This block is a small, fully associative store of branch targets that sits next to the instruction fetch address. In the same cycle that a fetch address is presented, it reports whether that address is a known taken branch. On a hit it also returns the predicted target, so fetch can redirect without losing a cycle. It learns only from branches that resolve taken. A not-taken outcome never creates an entry; it only removes one that already exists.

A slower main predictor sits behind it and checks every guess a few cycles later. When it disagrees, its override port rewrites the stored target or drops the entry. A resolved branch outcome reported in the same cycle for the same address outranks the override. New entries fill free slots first. Once every slot is in use, a rotating victim pointer chooses the entry to replace. A flush input empties the whole store in one cycle.

Top module: `taken_tgt_buf`

## Requirements
- R1: After reset, every lookup misses until an entry is allocated.
- R2: Lookup is combinational. `lk_hit` and `lk_tgt` reflect the stored state in the same cycle as `lk_pc`, and a miss drives `lk_tgt` to 0.
- R3: A resolved taken branch (`rs_valid`=1, `rs_taken`=1) whose PC matches no valid entry is allocated at the next clock edge. From then on, a lookup of that PC hits and returns `rs_tgt`.
- R4: A resolved taken branch whose PC matches a valid entry replaces that entry's target with `rs_tgt`.
- R5: A resolved not-taken branch invalidates a matching entry. When no entry matches, it creates nothing.
- R6: An override (`ov_valid`=1) whose PC matches a valid entry changes that entry at the next edge:
  - with `ov_taken`=1, the stored target becomes `ov_tgt`;
  - with `ov_taken`=0, the entry is invalidated.
  An override for a PC with no entry changes nothing.
- R7: Allocation uses the lowest-numbered invalid entry.
  - When all entries are valid, it replaces the entry named by a victim pointer.
  - The pointer is 0 after reset and advances by one per replacement, wrapping after ENTRIES-1.
  - Filling a free entry leaves the pointer unchanged.
- R8: A lookup and an update of the same PC in one cycle return the contents from before the update.
- R9: `flush`=1 clears every valid bit at the next edge. Any resolution or override presented in that cycle is ignored, and the victim pointer is unchanged.
- R10: When a resolution and an override name the same PC in the same cycle, the override is ignored.
- R11: Any PC may occupy any entry. The full PC is stored as the tag and compared against all entries in parallel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clear all entries at the next edge |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | Fetch address is a stored taken branch |
| lk_tgt | output | TGT_W | Predicted target, 0 on a miss |
| rs_valid | input | 1 | Resolved branch report present |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_tgt | input | TGT_W | Resolved target |
| rs_taken | input | 1 | Resolved branch was taken |
| ov_valid | input | 1 | Main predictor override present |
| ov_pc | input | PC_W | Address the override refers to |
| ov_taken | input | 1 | Main predictor says taken |
| ov_tgt | input | TGT_W | Main predictor target |

## Verification
The bench builds the block with ENTRIES=8 and 16-bit PC and target widths. Random PCs are drawn from a pool of twelve addresses, which keeps the store full most of the time. As a result, round-robin replacement, hole refilling after invalidation, and wrap of the victim pointer all occur within a few hundred cycles. The same small pool makes it common for a resolution and an override to name the same PC in the same cycle, and for a lookup to coincide with an update of the same PC. This exercises both the priority rule and the read-before-write behaviour.

// File: rtl/tgt_buf_pkg.sv
package tgt_buf_pkg;

    // Action a branch report applies to the store
    typedef enum logic [1:0] {
        SLOT_KEEP  = 2'd0,
        SLOT_WRITE = 2'd1,
        SLOT_KILL  = 2'd2,
        SLOT_ALLOC = 2'd3
    } slot_op_e;

    function automatic slot_op_e decide_op(input logic present, input logic match,
                                           input logic taken, input logic may_alloc);
        slot_op_e op;
        op = SLOT_KEEP;
        if (present) begin
            if (match)
                op = taken ? SLOT_WRITE : SLOT_KILL;
            else if (taken && may_alloc)
                op = SLOT_ALLOC;
        end
        return op;
    endfunction

endpackage

// File: rtl/tgt_buf_cam.sv
module tgt_buf_cam #(
    parameter int N  = 64,
    parameter int KW = 32,
    parameter int IW = 6
) (
    input  logic [N-1:0]         vld_i,
    input  logic [N-1:0][KW-1:0] tag_i,
    input  logic [KW-1:0]        key_i,
    output logic                 hit_o,
    output logic [IW-1:0]        idx_o
);

    logic [N-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign eq[g] = vld_i[g] && (tag_i[g] == key_i);
        end
    endgenerate

    // Tags are unique, so at most one bit of eq is set
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (eq[i])
                idx_o = idx_o | IW'(i);
        end
        hit_o = |eq;
    end

endmodule

// File: rtl/tgt_buf_victim.sv
module tgt_buf_victim #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  vld_i,
    input  logic [IW-1:0] rr_i,
    output logic [IW-1:0] idx_o,
    output logic          full_o
);

    logic [IW-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_i[i])
                free_idx = IW'(i);
        end
        full_o = &vld_i;
        idx_o  = full_o ? rr_i : free_idx;
    end

endmodule

// File: rtl/taken_tgt_buf.sv
module taken_tgt_buf
    import tgt_buf_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PC_W    = 32,
    parameter int TGT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic [TGT_W-1:0] lk_tgt,
    input  logic             rs_valid,
    input  logic [PC_W-1:0]  rs_pc,
    input  logic [TGT_W-1:0] rs_tgt,
    input  logic             rs_taken,
    input  logic             ov_valid,
    input  logic [PC_W-1:0]  ov_pc,
    input  logic             ov_taken,
    input  logic [TGT_W-1:0] ov_tgt
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][PC_W-1:0]   tag;
        logic [ENTRIES-1:0][TGT_W-1:0]  tgt;
        logic [IDX_W-1:0]               rr;
    } state_t;

    state_t st_d, st_q;

    logic             lk_match;
    logic [IDX_W-1:0] lk_idx;
    logic             rs_match;
    logic [IDX_W-1:0] rs_idx;
    logic             ov_match;
    logic [IDX_W-1:0] ov_idx;
    logic [IDX_W-1:0] vic_idx;
    logic             vic_full;
    logic             ov_live;
    slot_op_e         rs_op;
    slot_op_e         ov_op;

    tgt_buf_cam #(.N(ENTRIES), .KW(PC_W), .IW(IDX_W)) lk_cam_i (
        .vld_i (st_q.vld),
        .tag_i (st_q.tag),
        .key_i (lk_pc),
        .hit_o (lk_match),
        .idx_o (lk_idx)
    );

    tgt_buf_cam #(.N(ENTRIES), .KW(PC_W), .IW(IDX_W)) rs_cam_i (
        .vld_i (st_q.vld),
        .tag_i (st_q.tag),
        .key_i (rs_pc),
        .hit_o (rs_match),
        .idx_o (rs_idx)
    );

    tgt_buf_cam #(.N(ENTRIES), .KW(PC_W), .IW(IDX_W)) ov_cam_i (
        .vld_i (st_q.vld),
        .tag_i (st_q.tag),
        .key_i (ov_pc),
        .hit_o (ov_match),
        .idx_o (ov_idx)
    );

    tgt_buf_victim #(.N(ENTRIES), .IW(IDX_W)) victim_i (
        .vld_i  (st_q.vld),
        .rr_i   (st_q.rr),
        .idx_o  (vic_idx),
        .full_o (vic_full)
    );

    // Read side: pure function of the registered state
    always_comb begin
        lk_hit = lk_match;
        lk_tgt = lk_match ? st_q.tgt[lk_idx] : '0;
    end

    // Next-state: override first, resolution last so it wins on a shared slot
    always_comb begin
        st_d    = st_q;
        ov_live = ov_valid && !(rs_valid && (rs_pc == ov_pc));
        ov_op   = decide_op(ov_live, ov_match, ov_taken, 1'b0);
        rs_op   = decide_op(rs_valid, rs_match, rs_taken, 1'b1);

        if (flush) begin
            st_d.vld = '0;
        end else begin
            case (ov_op)
                SLOT_WRITE: st_d.tgt[ov_idx] = ov_tgt;
                SLOT_KILL:  st_d.vld[ov_idx] = 1'b0;
                default:    ;
            endcase

            case (rs_op)
                SLOT_WRITE: st_d.tgt[rs_idx] = rs_tgt;
                SLOT_KILL:  st_d.vld[rs_idx] = 1'b0;
                SLOT_ALLOC: begin
                    st_d.vld[vic_idx] = 1'b1;
                    st_d.tag[vic_idx] = rs_pc;
                    st_d.tgt[vic_idx] = rs_tgt;
                    if (vic_full)
                        st_d.rr = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/taken_tgt_buf_chk.sv
module taken_tgt_buf_chk #(
    parameter int PC_W  = 32,
    parameter int TGT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_hit,
    input logic [TGT_W-1:0] lk_tgt,
    input logic             rs_valid,
    input logic [PC_W-1:0]  rs_pc,
    input logic [TGT_W-1:0] rs_tgt,
    input logic             rs_taken,
    input logic             ov_valid,
    input logic [PC_W-1:0]  ov_pc,
    input logic             ov_taken,
    input logic [TGT_W-1:0] ov_tgt
);

    // R1
    empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    // R2
    miss_zero_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_tgt == '0));

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R3, R4
    taken_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken && !flush) |=>
            ((lk_pc != $past(rs_pc)) || (lk_hit && (lk_tgt == $past(rs_tgt)))));

    // R5
    not_taken_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_taken) |=> !(lk_hit && (lk_pc == $past(rs_pc))));

    // R6
    override_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_valid && !ov_taken && !(rs_valid && (rs_pc == ov_pc))) |=>
            !(lk_hit && (lk_pc == $past(ov_pc))));

endmodule

bind taken_tgt_buf taken_tgt_buf_chk #(.PC_W(PC_W), .TGT_W(TGT_W)) chk_i (.*);

// File: tb/taken_tgt_buf_tb_top.sv
module taken_tgt_buf_tb_top;

    localparam int N  = 8;
    localparam int AW = 16;
    localparam int NPOOL = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic [AW-1:0] lk_pc = '0;
    logic          lk_hit;
    logic [AW-1:0] lk_tgt;
    logic          rs_valid = 1'b0;
    logic [AW-1:0] rs_pc = '0;
    logic [AW-1:0] rs_tgt = '0;
    logic          rs_taken = 1'b0;
    logic          ov_valid = 1'b0;
    logic [AW-1:0] ov_pc = '0;
    logic          ov_taken = 1'b0;
    logic [AW-1:0] ov_tgt = '0;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference store
    logic          m_vld [N];
    logic [AW-1:0] m_pc  [N];
    logic [AW-1:0] m_tgt [N];
    int            m_rr;

    always #4 clk = ~clk;

    taken_tgt_buf #(.ENTRIES(N), .PC_W(AW), .TGT_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_tgt(lk_tgt),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_tgt(rs_tgt), .rs_taken(rs_taken),
        .ov_valid(ov_valid), .ov_pc(ov_pc), .ov_taken(ov_taken), .ov_tgt(ov_tgt)
    );

    function automatic logic [AW-1:0] pool(input int i);
        return AW'(16'h1000 + i * 4);
    endfunction

    function automatic int find(input logic [AW-1:0] pc);
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_pc[i] == pc) return i;
        return -1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_pc[i] = '0; m_tgt[i] = '0;
        end
        m_rr = 0;
    endtask

    task automatic model_apply(input logic rv, input logic [AW-1:0] rpc,
                               input logic [AW-1:0] rt, input logic rk,
                               input logic ov, input logic [AW-1:0] opc,
                               input logic ok, input logic [AW-1:0] ot,
                               input logic fl);
        int ri, oi, vic;
        logic full, ovl;
        if (fl) begin
            for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
            return;
        end
        ovl = ov && !(rv && rpc == opc);
        ri = find(rpc);
        oi = find(opc);
        full = 1'b1; vic = m_rr;
        for (int i = N - 1; i >= 0; i--)
            if (!m_vld[i]) begin full = 1'b0; vic = i; end
        if (ovl && oi >= 0) begin
            if (ok) m_tgt[oi] = ot; else m_vld[oi] = 1'b0;
        end
        if (rv) begin
            if (ri >= 0) begin
                if (rk) m_tgt[ri] = rt; else m_vld[ri] = 1'b0;
            end else if (rk) begin
                m_vld[vic] = 1'b1; m_pc[vic] = rpc; m_tgt[vic] = rt;
                if (full) m_rr = (m_rr + 1) % N;
            end
        end
    endtask

    task automatic step(input string req, input logic [AW-1:0] lpc,
                        input logic rv, input logic [AW-1:0] rpc,
                        input logic [AW-1:0] rt, input logic rk,
                        input logic ov, input logic [AW-1:0] opc,
                        input logic ok, input logic [AW-1:0] ot,
                        input logic fl);
        int k;
        logic          e_hit;
        logic [AW-1:0] e_tgt;
        @(negedge clk);
        lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_tgt = rt; rs_taken = rk;
        ov_valid = ov; ov_pc = opc; ov_taken = ok; ov_tgt = ot; flush = fl;
        #1;
        k = find(lpc);
        e_hit = (k >= 0);
        e_tgt = e_hit ? m_tgt[k] : '0;
        n_cmp++;
        if (lk_hit !== e_hit || lk_tgt !== e_tgt) begin
            n_bad++;
            $display("FAIL %s pc=%h hit=%b exp %b tgt=%h exp %h",
                     req, lpc, lk_hit, e_hit, lk_tgt, e_tgt);
        end
        @(posedge clk);
        model_apply(rv, rpc, rt, rk, ov, opc, ok, ot, fl);
    endtask

    task automatic look(input string req, input logic [AW-1:0] lpc);
        step(req, lpc, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic resolve(input logic [AW-1:0] pc, input logic [AW-1:0] t, input logic tk);
        step("R3", pc, 1'b1, pc, t, tk, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic override(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] t);
        step("R6", pc, 1'b0, '0, '0, 1'b0, 1'b1, pc, tk, t, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look("R1", pool(0));
        look("R1", pool(5));
        // R5: not-taken on a miss creates nothing
        step("R5", pool(0), 1'b1, pool(0), 16'h0AA0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
        look("R5", pool(0));
        // R3: taken allocates
        resolve(pool(1), 16'hAAA0, 1'b1);
        look("R3", pool(1));
        // R8: same-cycle lookup sees old target, R4 sees new next cycle
        step("R8", pool(1), 1'b1, pool(1), 16'hBBB0, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
        look("R4", pool(1));
        // R6: override correct, miss, kill
        override(pool(1), 1'b1, 16'hCCC0);
        look("R6", pool(1));
        override(pool(2), 1'b1, 16'hDDD0);
        look("R6", pool(2));
        override(pool(1), 1'b0, '0);
        look("R6", pool(1));
        // R10: resolution outranks override on the same PC
        resolve(pool(3), 16'h3330, 1'b1);
        step("R10", pool(3), 1'b1, pool(3), 16'h4440, 1'b1, 1'b1, pool(3), 1'b0, '0, 1'b0);
        look("R10", pool(3));
        resolve(pool(3), '0, 1'b0);
        look("R5", pool(3));
        // R9: fill, then flush with a competing allocation
        for (int i = 0; i < N; i++) resolve(pool(i), AW'(16'h5000 + i), 1'b1);
        step("R9", pool(0), 1'b1, pool(8), 16'h5888, 1'b1, 1'b1, pool(1), 1'b1, 16'h1111, 1'b1);
        for (int i = 0; i < 9; i++) look("R9", pool(i));
        // R7: fill in index order, then rotate the victim pointer
        for (int i = 0; i < N; i++) resolve(pool(i), AW'(16'h6000 + i), 1'b1);
        resolve(pool(8), 16'h6888, 1'b1);
        look("R7", pool(0));
        look("R7", pool(8));
        resolve(pool(9), 16'h6999, 1'b1);
        look("R7", pool(1));
        resolve(pool(5), '0, 1'b0);
        resolve(pool(10), 16'h6AAA, 1'b1);
        look("R7", pool(10));
        resolve(pool(11), 16'h6BBB, 1'b1);
        look("R7", pool(2));
        look("R7", pool(3));
        look("R7", pool(11));

        // R11, R2: random mixed traffic over a small pool
        for (int n = 0; n < 4000; n++) begin
            logic          rv, rk, ov, ok, fl;
            logic [AW-1:0] rpc, opc, lpc;
            rv  = ($urandom_range(1, 0) == 1);
            rk  = ($urandom_range(9, 0) < 6);
            ov  = ($urandom_range(3, 0) == 0);
            ok  = ($urandom_range(1, 0) == 1);
            fl  = ($urandom_range(63, 0) == 0);
            rpc = pool($urandom_range(NPOOL - 1, 0));
            opc = ($urandom_range(3, 0) == 0) ? rpc : pool($urandom_range(NPOOL - 1, 0));
            lpc = ($urandom_range(3, 0) == 0) ? rpc : pool($urandom_range(NPOOL - 1, 0));
            step("R11", lpc, rv, rpc, AW'($urandom()), rk, ov, opc, ok, AW'($urandom()), fl);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule